// File: doc/BRIEF.md
# MCU Reset and Brown-out Controller

This block decides when the core of a small 8-bit microcontroller is held in reset and where it resumes afterwards. It merges four sources: a power-good indication that acts as the block's own synchronous reset, an external reset pin, a software reset bit, and a digital brown-out comparator output. The pin and the comparator are asynchronous. Each one passes through a two-flop synchronizer and then through a counter that only accepts a run of consecutive high samples.

Any accepted reset holds the core reset output for a fixed stretch and then releases it on a clock edge. While reset is released, the fetch vector output reads 0000H. A brown-out can instead raise an interrupt if software has set the enable bit. While that interrupt is pending, the vector output reads 004BH.

Software reaches three byte-wide registers through a small write-strobe bus with combinational read data. The control register holds the software reset bit, the brown-out enable bit, the watchdog status bit and a write-only acknowledge. The status register holds the power-on flag and the pending interrupt. The cause register reports the source of the last reset.

Top module: `rstctl_top`

## Requirements
- R1: The external pin is taken as a reset only after its synchronized level has been high for 24 consecutive clocks. A 24-clock pulse on the pin asserts the core reset two clocks after the pulse ends. A pulse of 23 clocks or less has no effect.
- R2: The core reset output stays high while the power-good reset is high. It then stays high for exactly 24 clocks after the last reset trigger and falls on a clock edge.
- R3: The vector output reads 0000H unless a brown-out interrupt is pending, in which case it reads 004BH.
- R4: The software reset fires only when a control write (address 0) sets bit 0 from 0 to 1. Writing 1 while bit 0 is already 1 causes no reset, and the written bits are simply stored.
- R5: A software reset leaves the software reset bit (bit 0) at 1 and keeps the watchdog status bit (bit 2). It clears the enable bit (bit 1) and any pending interrupt, and it leaves the power-on flag untouched.
- R6: A pin or brown-out reset clears all control bits, including bit 0 and the watchdog status bit.
- R7: The brown-out input is acted on only after its synchronized level has been high for 4 consecutive clocks. Shorter pulses have no effect.
- R8: With the enable bit set, a newly accepted brown-out sets the pending interrupt and does not reset the core.
- R9: With the enable bit clear, an accepted brown-out resets the core and keeps it in reset for as long as the brown-out lasts.
- R10: If software clears the enable bit while an accepted brown-out is still present, the core is reset in the following cycle.
- R11: The power-on flag (status register, address 1, bit 0) is 1 after power-good reset. It clears only when a status write has bit 0 equal to 0. Writing 1 to it and the other reset sources leave it unchanged.
- R12: The cause register (address 2, bits 1:0) holds the source of the last reset: 0 for pin, 1 for power-on, 2 for software, 3 for brown-out.
- R13: The pending interrupt (status bit 1) clears on a control write with bit 3 set, or on any reset. A second brown-out that arrives while it is pending does not queue another request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-good reset, active high, synchronous |
| ext_rst_i | input | 1 | External reset pin, asynchronous, active high |
| bod_i | input | 1 | Brown-out comparator output, asynchronous, active high |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 status, 2 cause |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| core_rst_o | output | 1 | Core reset, active high |
| bo_irq_o | output | 1 | Brown-out interrupt request |
| vec_o | output | 16 | Fetch vector: 0000H or 004BH |

## Verification
Several relations are checked on every cycle by the embedded properties. A trigger always produces core reset on the next cycle, and reset never falls right after a trigger. A rising pending request always follows a cycle with the enable bit set and no reset. The request stays set unless it is acknowledged or a reset occurs. The power-on flag changes only through a clearing write, and a software reset keeps the watchdog status bit. Clearing the enable bit during an accepted brown-out is followed by a trigger.

Other behaviour can only be shown by the bench scenarios. These include the exact 23-versus-24 and 3-versus-4 pulse boundaries, the 24-clock release timing, the register values after each kind of reset, the cause codes, and the absence of a second interrupt after acknowledge.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;
    localparam int unsigned VEC_W  = 16;

    localparam logic [VEC_W-1:0] RESET_VEC = 16'h0000;
    localparam logic [VEC_W-1:0] BO_VEC    = 16'h004B;

    typedef enum logic [1:0] {
        CAUSE_PIN = 2'd0,
        CAUSE_POR = 2'd1,
        CAUSE_SW  = 2'd2,
        CAUSE_BOD = 2'd3
    } cause_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_STAT  = 2'd1,
        REG_CAUSE = 2'd2,
        REG_NONE  = 2'd3
    } reg_e;

    // control register low nibble, bit 3 down to bit 0
    typedef struct packed {
        logic ack;
        logic wdts;
        logic ebo;
        logic swr;
    } ctrl_t;

    typedef struct packed {
        logic pin;
        logic bod;
        logic sw;
    } trig_t;

    // hard sources outrank the software request
    function automatic cause_e pick_cause(trig_t t);
        if (t.pin)      return CAUSE_PIN;
        else if (t.bod) return CAUSE_BOD;
        else            return CAUSE_SW;
    endfunction

endpackage

// File: rtl/rstctl_qual.sv
module rstctl_qual #(
    parameter int unsigned HOLD = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic qual_o
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          level;

    assign level = sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], async_i};
            if (!level)
                run_q <= '0;
            else if (run_q != LAST)
                run_q <= run_q + 1'b1;
        end
    end

    assign qual_o = level && (run_q == LAST);

    // R1 R7
    qual_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(qual_o) |-> $past(level));

endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
    parameter int unsigned HOLD = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic core_rst_o
);
    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || trig_i)
            left_q <= FULL;
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign core_rst_o = (left_q != '0);

    // R2
    trig_asserts_chk: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> core_rst_o);

    // R2
    no_release_on_trig_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_o) |-> !$past(trig_i));

endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
    import rstctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_qual_i,
    input  logic              bod_qual_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              trig_o,
    output logic              irq_o
);
    logic   swr_q, ebo_q, wdts_q, pof_q, pend_q, bod_prev_q;
    cause_e cause_q;
    ctrl_t  wr;
    trig_t  t;
    logic   wr_ctrl, wr_stat, hard, bod_rise;

    assign wr      = ctrl_t'(bus_wdata_i[3:0]);
    assign wr_ctrl = bus_we_i && (reg_e'(bus_addr_i) == REG_CTRL);
    assign wr_stat = bus_we_i && (reg_e'(bus_addr_i) == REG_STAT);

    assign t.pin    = pin_qual_i;
    assign t.bod    = bod_qual_i && !ebo_q;
    assign t.sw     = wr_ctrl && wr.swr && !swr_q;
    assign hard     = t.pin || t.bod;
    assign trig_o   = hard || t.sw;
    assign bod_rise = bod_qual_i && !bod_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            swr_q      <= 1'b0;
            ebo_q      <= 1'b0;
            wdts_q     <= 1'b0;
            pend_q     <= 1'b0;
            bod_prev_q <= 1'b0;
            cause_q    <= CAUSE_POR;
        end else begin
            bod_prev_q <= bod_qual_i;
            if (hard) begin
                swr_q   <= 1'b0;
                ebo_q   <= 1'b0;
                wdts_q  <= 1'b0;
                pend_q  <= 1'b0;
                cause_q <= pick_cause(t);
            end else if (t.sw) begin
                swr_q   <= 1'b1;
                ebo_q   <= 1'b0;
                pend_q  <= 1'b0;
                cause_q <= CAUSE_SW;
            end else begin
                if (wr_ctrl) begin
                    swr_q  <= wr.swr;
                    ebo_q  <= wr.ebo;
                    wdts_q <= wr.wdts;
                end
                if (ebo_q && bod_rise)
                    pend_q <= 1'b1;
                else if (wr_ctrl && wr.ack)
                    pend_q <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pof_q <= 1'b1;
        else if (wr_stat && !bus_wdata_i[0])
            pof_q <= 1'b0;
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (reg_e'(bus_addr_i))
            REG_CTRL:  bus_rdata_o[2:0] = {wdts_q, ebo_q, swr_q};
            REG_STAT:  bus_rdata_o[1:0] = {pend_q, pof_q};
            REG_CAUSE: bus_rdata_o[1:0] = cause_q;
            default:   bus_rdata_o = '0;
        endcase
    end

    assign irq_o = pend_q;

    // R8
    irq_only_when_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> ($past(ebo_q) && !$past(trig_o)));

    // R13
    pending_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !(wr_ctrl && wr.ack) && !trig_o) |=> pend_q);

    // R11
    pof_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_stat && !bus_wdata_i[0]) |=> (pof_q == $past(pof_q)));

    // R5
    sw_keeps_wdts_chk: assert property (@(posedge clk) disable iff (rst)
        (t.sw && !hard) |=> (swr_q && (wdts_q == $past(wdts_q)) && !ebo_q));

    // R10
    ebo_clear_resets_chk: assert property (@(posedge clk) disable iff (rst)
        (ebo_q && bod_qual_i && wr_ctrl && !wr.ebo && !wr.swr) |=> (trig_o || !bod_qual_i));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int unsigned PIN_HOLD = 24,
    parameter int unsigned BOD_HOLD = 4,
    parameter int unsigned RST_HOLD = 24
) (
    input  logic              clk,
    input  logic              por_i,
    input  logic              ext_rst_i,
    input  logic              bod_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              core_rst_o,
    output logic              bo_irq_o,
    output logic [VEC_W-1:0]  vec_o
);
    logic pin_qual, bod_qual, trig;

    rstctl_qual #(.HOLD(PIN_HOLD)) u_pin_qual (
        .clk(clk), .rst(por_i), .async_i(ext_rst_i), .qual_o(pin_qual)
    );

    rstctl_qual #(.HOLD(BOD_HOLD)) u_bod_qual (
        .clk(clk), .rst(por_i), .async_i(bod_i), .qual_o(bod_qual)
    );

    rstctl_regs u_regs (
        .clk(clk), .rst(por_i),
        .pin_qual_i(pin_qual), .bod_qual_i(bod_qual),
        .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .trig_o(trig), .irq_o(bo_irq_o)
    );

    rstctl_stretch #(.HOLD(RST_HOLD)) u_stretch (
        .clk(clk), .rst(por_i), .trig_i(trig), .core_rst_o(core_rst_o)
    );

    assign vec_o = bo_irq_o ? BO_VEC : RESET_VEC;

    // R3
    vec_follows_irq_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(bo_irq_o) |-> (vec_o == BO_VEC));

endmodule

// File: tb/rstctl_top_test.sv
module rstctl_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       ext_rst_i = 1'b0;
    logic       bod_i = 1'b0;
    logic       bus_we_i = 1'b0;
    logic [1:0] bus_addr_i = 2'd0;
    logic [7:0] bus_wdata_i = 8'd0;
    logic [7:0] bus_rdata_o;
    logic       core_rst_o;
    logic       bo_irq_o;
    logic [15:0] vec_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    event  kick;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstctl_top uut (
        .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i), .bod_i(bod_i),
        .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .core_rst_o(core_rst_o),
        .bo_irq_o(bo_irq_o), .vec_o(vec_o)
    );

    // monitor: pops expected items and compares against live outputs
    initial begin
        forever begin
            @(kick);
            while (sb.size() != 0) begin
                item_t it;
                logic [15:0] got;
                it = sb.pop_front();
                case (it.sel)
                    0: got = {15'd0, core_rst_o};
                    1: got = {15'd0, bo_irq_o};
                    2: got = vec_o;
                    default: got = {8'd0, bus_rdata_o};
                endcase
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic push(input int sel, input logic [15:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        -> kick;
        #1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_rst(input logic v, input string tag);
        push(0, {15'd0, v}, tag);
    endtask

    task automatic exp_reg(input logic [1:0] a, input logic [7:0] v, input string tag);
        bus_addr_i = a;
        #1;
        push(3, {8'd0, v}, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        tick(1);
        bus_we_i = 1'b0; bus_wdata_i = 8'd0;
    endtask

    task automatic pin_pulse(input int len);
        ext_rst_i = 1'b1;
        tick(len);
        ext_rst_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        exp_rst(1'b1, "R2 held during power-good reset");
        por_i = 1'b0;
        tick(23);
        exp_rst(1'b1, "R2 still high 23 clocks after por");
        tick(1);
        exp_rst(1'b0, "R2 released after 24 clocks");
        exp_reg(2'd2, 8'h01, "R12 cause power-on");
        exp_reg(2'd1, 8'h01, "R11 pof set after power-up");
        exp_reg(2'd0, 8'h00, "R6 control clear after power-up");
        push(2, 16'h0000, "R3 vector 0000H after reset");

        // R1 short pin pulse ignored
        pin_pulse(23);
        tick(30);
        exp_rst(1'b0, "R1 23-clock pin pulse ignored");
        exp_reg(2'd2, 8'h01, "R1 cause unchanged after short pulse");

        // R1 qualified pulse
        pin_pulse(24);
        tick(2);
        exp_rst(1'b1, "R1 24-clock pin pulse resets");
        exp_reg(2'd2, 8'h00, "R12 cause pin");
        tick(23);
        exp_rst(1'b1, "R2 stretch 23 clocks");
        tick(1);
        exp_rst(1'b0, "R2 stretch ends at 24");
        exp_reg(2'd1, 8'h01, "R11 pin reset leaves pof");

        // R7 short brown-out ignored
        bod_i = 1'b1; tick(3); bod_i = 1'b0;
        tick(10);
        exp_rst(1'b0, "R7 3-clock brown-out ignored");

        // R7 R9 qualified brown-out without enable
        bod_i = 1'b1; tick(4); bod_i = 1'b0;
        tick(2);
        exp_rst(1'b1, "R7 4-clock brown-out resets");
        exp_reg(2'd2, 8'h03, "R12 cause brown-out");
        tick(30);
        exp_rst(1'b0, "R9 released after brown-out");
        bod_i = 1'b1; tick(40);
        exp_rst(1'b1, "R9 held while brown-out lasts");
        bod_i = 1'b0;
        tick(40);
        exp_rst(1'b0, "R9 released after long brown-out");

        // R8 R13 interrupt path
        wr(2'd0, 8'h02);
        exp_reg(2'd0, 8'h02, "R8 enable bit stored");
        bod_i = 1'b1; tick(6);
        push(1, 16'd1, "R8 interrupt raised");
        push(2, 16'h004B, "R3 vector 004BH while pending");
        exp_rst(1'b0, "R8 no core reset with enable");
        tick(5); bod_i = 1'b0; tick(5);
        bod_i = 1'b1; tick(8); bod_i = 1'b0; tick(5);
        push(1, 16'd1, "R13 still pending after second brown-out");
        wr(2'd0, 8'h0A);
        push(1, 16'd0, "R13 acknowledge clears request");
        push(2, 16'h0000, "R3 vector back to 0000H");
        tick(10);
        push(1, 16'd0, "R13 no queued second request");
        exp_rst(1'b0, "R8 core still running");

        // R10 clear enable during active brown-out
        bod_i = 1'b1; tick(8);
        push(1, 16'd1, "R10 pending before clear");
        wr(2'd0, 8'h00);
        tick(1);
        exp_rst(1'b1, "R10 clearing enable resets core");
        exp_reg(2'd2, 8'h03, "R10 cause brown-out");
        push(1, 16'd0, "R13 reset clears pending");
        bod_i = 1'b0;
        tick(40);
        exp_rst(1'b0, "R10 released");

        // R4 R5 software reset
        wr(2'd0, 8'h06);
        exp_reg(2'd0, 8'h06, "R5 enable and watchdog bit set");
        wr(2'd0, 8'h01);
        exp_rst(1'b1, "R4 rising software bit resets");
        exp_reg(2'd0, 8'h05, "R5 swr and wdts kept, enable cleared");
        exp_reg(2'd2, 8'h02, "R12 cause software");
        exp_reg(2'd1, 8'h01, "R5 pof untouched");
        tick(30);
        exp_rst(1'b0, "R2 software reset released");
        wr(2'd0, 8'h07);
        exp_rst(1'b0, "R4 rewrite of 1 no reset");
        exp_reg(2'd0, 8'h07, "R4 bits stored without reset");
        wr(2'd0, 8'h06);
        wr(2'd0, 8'h05);
        exp_rst(1'b1, "R4 new 0-to-1 resets");
        exp_reg(2'd0, 8'h05, "R5 enable cleared again");
        tick(30);

        // R6 hard reset clears control
        pin_pulse(24);
        tick(2);
        exp_rst(1'b1, "R6 pin reset active");
        exp_reg(2'd0, 8'h00, "R6 pin reset clears swr and wdts");
        tick(30);

        // R11 power-on flag
        wr(2'd1, 8'h00);
        exp_reg(2'd1, 8'h00, "R11 pof cleared by write of 0");
        pin_pulse(24);
        tick(30);
        exp_reg(2'd1, 8'h00, "R11 pin reset does not set pof");
        wr(2'd1, 8'h01);
        exp_reg(2'd1, 8'h00, "R11 write of 1 has no effect");

        #1;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule